// File: doc/BRIEF.md
# Tagged Receive Collector for a Multi-Line Serial Multiplexer

This block gathers finished characters from several per-line serial receivers and hands them to software one at a time through a single read-only buffer word. Each receiver sends a one-cycle strobe together with its character and its framing-error and parity-error flags. The collector first checks that the line's receiver is enabled. It then limits the character to the line's configured length and picks one waiting line per cycle, lowest number first. The winning word goes into a small first-in first-out queue, tagged with its line number.

Software empties the queue by reading the buffer word over and over until the valid bit reads 0. Every read of a valid word removes it from the queue. A receive-done flag shows that the queue holds something. An interrupt request is raised while receive-done is set and the receive interrupt enable is on.

Line settings are written one line at a time: a line number together with a parameter word. The parameter word holds the character length, the stop-bit count, the parity settings and the receiver enable. The framing settings are passed back out to each line's receiver. No break status bit exists. A break reaches software as a zero character with its framing-error bit set.

Top module: `mrx_collector`

## Requirements
- R1: After reset the buffer word reads all zeros, rx_done and irq are 0, and every line's format output is 0.
- R2: The buffer word is laid out as follows, with the default of 4 lines and line field width LW = 2. Bits [7:0] hold the character. Bits [LW+7:8] hold the source line. Bit LW+8 is the parity error. Bit LW+9 is the framing error. Bit LW+10 is the overrun. Bit LW+11 is the valid bit.
- R3: While the queue holds a word, the buffer shows the oldest word with the valid bit set, and a cycle with rbuf_rd high removes that word. When the queue is empty, the buffer reads all zeros and a read changes nothing.
- R4: If several lines deliver a character in the same cycle, the lowest-numbered line is stored in that cycle. The others are held and stored in the following cycles in ascending line order.
- R5: A character arriving on a line whose receiver enable is 0 is dropped.
- R6: The parameter word is written with lp_wr to the line named by lp_line. Its bits are: [1:0] length code (0 to 3 for 5 to 8 bits), [2] two stop bits, [3] parity enable, [4] odd parity, [5] receiver enable. Bits [4:0] appear on that line's 5-bit slice of line_fmt.
- R7: A character shorter than 8 bits is stored with its unused upper bits forced to zero.
- R8: The framing-error and parity-error inputs are stored unchanged with their character. A zero character with a framing error is stored as such, and its overrun bit is 0.
- R9: The queue holds 16 words. A character that wins arbitration while the queue is full and no word is being read is discarded. The next word stored after that has its overrun bit set, and later words have it clear.
- R10: rx_done is 1 exactly when the queue holds a word. irq is 1 exactly when rx_done and rx_ie are both 1.
- R11: While scan_en is 0, no character is accepted or stored.
- R12: A one-cycle clr_cmd empties the queue, drops held characters and clears pending overrun, so rx_done reads 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Master enable for accepting and storing characters |
| clr_cmd | input | 1 | One-cycle clear of queue and held state |
| rx_ie | input | 1 | Receive interrupt enable |
| lp_wr | input | 1 | Line-parameter write strobe |
| lp_line | input | 2 | Line addressed by the parameter write |
| lp_word | input | 6 | Parameter word (length, stops, parity, enable) |
| rx_stb | input | 4 | Per-line character-complete strobe |
| rx_char | input | 32 | Per-line raw character, 8 bits per line |
| rx_ferr | input | 4 | Per-line framing error |
| rx_perr | input | 4 | Per-line parity error |
| rbuf_rd | input | 1 | Read of the buffer word (pops when valid) |
| rbuf | output | 14 | Tagged receive buffer word |
| rx_done | output | 1 | Queue not empty |
| irq | output | 1 | Receive interrupt request |
| line_fmt | output | 20 | Per-line framing settings, 5 bits per line |

## Verification
The assertions check the following on every cycle. At most one line is granted per cycle. A held character stays held until it is granted. The queue never counts past its depth, and a lone read lowers the count by one. The interrupt never fires without a valid word on the buffer. A clear leaves the block empty. With scan disabled, an empty block stays empty. The ascending drain order, the zero-extension of short characters, the dropping of characters from disabled lines, the break encoding, and the exact placement of the overrun mark after a full queue can only be shown by the bench. It does this by writing known line settings, reading the buffer word back, and comparing each tagged word with what is expected.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
   localparam int CHAR_W = 8;
   localparam int FMT_W  = 5;
   localparam int LP_W   = 6;

   typedef struct packed {
      logic       rx_en;
      logic       par_odd;
      logic       par_en;
      logic       two_stop;
      logic [1:0] len;
   } line_cfg_t;

   // keep (len+5) low bits of a character
   function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] len);
      return {CHAR_W{1'b1}} >> (2'd3 - len);
   endfunction
endpackage

// File: rtl/mrx_line_slot.sv
module mrx_line_slot
   import mrx_pkg::*;
#(
   parameter int SLOT_W = CHAR_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              acc,
   input  logic [SLOT_W-1:0] din,
   input  logic              grant,
   output logic              req,
   output logic [SLOT_W-1:0] dout,
   output logic              lost
);
   logic              pv_q;
   logic [SLOT_W-1:0] pw_q;

   assign req  = pv_q | acc;
   assign dout = pv_q ? pw_q : din;
   assign lost = acc & pv_q & ~grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv_q <= 1'b0;
         pw_q <= '0;
      end else if (clr) begin
         pv_q <= 1'b0;
      end else if (grant) begin
         if (pv_q && acc) pw_q <= din;
         else if (pv_q)   pv_q <= 1'b0;
      end else if (!pv_q && acc) begin
         pv_q <= 1'b1;
         pw_q <= din;
      end
   end

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pv_q && !grant && !clr) |=> pv_q);
endmodule

// File: rtl/mrx_prio_pick.sv
module mrx_prio_pick #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          en,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx
);
   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i] && en) begin
            grant = '0;
            grant[i] = 1'b1;
            idx = IW'(i);
         end
      end
   end

   // R4
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
endmodule

// File: rtl/mrx_fifo.sv
module mrx_fifo #(
   parameter int W     = 14,
   parameter int DEPTH = 16,
   parameter int PW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("mrx_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));
   assign rdata = mem[rp_q];

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   // R9
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   // R3
   pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !clr) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/mrx_collector.sv
module mrx_collector
   import mrx_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int Q_DEPTH   = 16,
   parameter int LINE_W    = $clog2(NUM_LINES),
   parameter int WORD_W    = CHAR_W + LINE_W + 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        scan_en,
   input  logic                        clr_cmd,
   input  logic                        rx_ie,
   input  logic                        lp_wr,
   input  logic [LINE_W-1:0]           lp_line,
   input  logic [LP_W-1:0]             lp_word,
   input  logic [NUM_LINES-1:0]        rx_stb,
   input  logic [NUM_LINES*CHAR_W-1:0] rx_char,
   input  logic [NUM_LINES-1:0]        rx_ferr,
   input  logic [NUM_LINES-1:0]        rx_perr,
   input  logic                        rbuf_rd,
   output logic [WORD_W-1:0]           rbuf,
   output logic                        rx_done,
   output logic                        irq,
   output logic [NUM_LINES*FMT_W-1:0]  line_fmt
);
   if (NUM_LINES < 2) begin : g_bad_lines
      $error("mrx_collector: NUM_LINES must be at least 2");
   end

   localparam int SLOT_W = CHAR_W + 2;
   localparam int QW     = WORD_W - 1;
   localparam int DV     = WORD_W - 1;

   line_cfg_t               cfg_q [NUM_LINES];
   logic [NUM_LINES-1:0]    req, grant, lost;
   logic [SLOT_W-1:0]       sdata [NUM_LINES];
   logic [LINE_W-1:0]       gidx;
   logic [SLOT_W-1:0]       gword;
   logic [QW-1:0]           qin, qout;
   logic                    q_empty, q_full, any_g, push, pop, dropped, ovr_q;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic [SLOT_W-1:0] din;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  cfg_q[i] <= '0;
         else if (lp_wr && lp_line == LINE_W'(i))     cfg_q[i] <= line_cfg_t'(lp_word);
      end

      assign line_fmt[i*FMT_W +: FMT_W] = cfg_q[i][FMT_W-1:0];
      assign din = {rx_ferr[i], rx_perr[i],
                    rx_char[i*CHAR_W +: CHAR_W] & len_mask(cfg_q[i].len)};

      mrx_line_slot #(.SLOT_W(SLOT_W)) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr_cmd),
         .acc   (rx_stb[i] & cfg_q[i].rx_en & scan_en & ~clr_cmd),
         .din   (din),
         .grant (grant[i]),
         .req   (req[i]),
         .dout  (sdata[i]),
         .lost  (lost[i])
      );
   end

   mrx_prio_pick #(.N(NUM_LINES), .IW(LINE_W)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .en    (scan_en & ~clr_cmd),
      .grant (grant),
      .idx   (gidx)
   );

   always_comb begin
      gword = '0;
      for (int i = 0; i < NUM_LINES; i++)
         if (grant[i]) gword = gword | sdata[i];
   end

   assign any_g   = |grant;
   assign pop     = rbuf_rd & ~q_empty & ~clr_cmd;
   assign push    = any_g & (~q_full | pop);
   assign dropped = any_g & q_full & ~pop;
   // {oerr, ferr, perr, line, char}
   assign qin     = {ovr_q, gword[SLOT_W-1], gword[SLOT_W-2], gidx, gword[CHAR_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_q <= 1'b0;
      else if (clr_cmd) ovr_q <= 1'b0;
      else if (push)    ovr_q <= |lost;
      else              ovr_q <= ovr_q | dropped | (|lost);
   end

   mrx_fifo #(.W(QW), .DEPTH(Q_DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_cmd),
      .push  (push),
      .wdata (qin),
      .pop   (pop),
      .rdata (qout),
      .empty (q_empty),
      .full  (q_full)
   );

   assign rbuf    = q_empty ? '0 : {1'b1, qout};
   assign rx_done = ~q_empty;
   assign irq     = rx_done & rx_ie;

   // R10
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> rbuf[DV]);
   // R12
   clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cmd |=> !rx_done);
   // R11
   scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_en && !rx_done) |=> !rx_done);
endmodule

// File: tb/sim_mrx_collector.sv
`timescale 1ns/1ps
module sim_mrx_collector;
   localparam int N  = 4;
   localparam int LW = 2;
   localparam int WW = 8 + LW + 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scan_en = 1'b0, clr_cmd = 1'b0, rx_ie = 1'b0, lp_wr = 1'b0;
   logic [LW-1:0] lp_line = '0;
   logic [5:0]    lp_word = '0;
   logic [N-1:0]  rx_stb = '0, rx_ferr = '0, rx_perr = '0;
   logic [N*8-1:0] rx_char = '0;
   logic          rbuf_rd = 1'b0;
   logic [WW-1:0] rbuf;
   logic          rx_done, irq;
   logic [N*5-1:0] line_fmt;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mrx_collector u0 (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .clr_cmd(clr_cmd),
      .rx_ie(rx_ie), .lp_wr(lp_wr), .lp_line(lp_line), .lp_word(lp_word),
      .rx_stb(rx_stb), .rx_char(rx_char), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
      .rbuf_rd(rbuf_rd), .rbuf(rbuf), .rx_done(rx_done), .irq(irq),
      .line_fmt(line_fmt)
   );

   function automatic logic [WW-1:0] mk(bit oe, bit fe, bit pe, int ln, logic [7:0] ch);
      return {1'b1, oe, fe, pe, LW'(ln), ch};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg(int ln, logic [5:0] w);
      lp_wr = 1'b1; lp_line = LW'(ln); lp_word = w;
      @(negedge clk);
      lp_wr = 1'b0;
   endtask

   task automatic send(int ln, logic [7:0] ch, bit fe, bit pe);
      rx_stb = '0; rx_stb[ln] = 1'b1;
      rx_char[ln*8 +: 8] = ch; rx_ferr[ln] = fe; rx_perr[ln] = pe;
      @(negedge clk);
      rx_stb = '0; rx_ferr = '0; rx_perr = '0;
   endtask

   task automatic pop_chk(string req, logic [WW-1:0] exp);
      chk(req, 32'(rbuf), 32'(exp));
      rbuf_rd = 1'b1;
      @(negedge clk);
      rbuf_rd = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 rbuf", 32'(rbuf), 0);
      chk("R1 done", 32'(rx_done), 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 fmt", 32'(line_fmt), 0);
   endtask

   task automatic t_cfg;
      cfg(0, 6'b10_0011);
      cfg(1, 6'b11_1100);
      cfg(2, 6'b10_0111);
      cfg(3, 6'b00_0011);
      chk("R6 fmt", 32'(line_fmt), 32'({5'b00011, 5'b00111, 5'b11100, 5'b00011}));
   endtask

   task automatic t_single;
      send(2, 8'hA5, 0, 0);
      chk("R10 done", 32'(rx_done), 1);
      chk("R10 irq off", 32'(irq), 0);
      pop_chk("R2 word", mk(0, 0, 0, 2, 8'hA5));
      chk("R3 empty", 32'(rbuf), 0);
      rbuf_rd = 1'b1; @(negedge clk); rbuf_rd = 1'b0;
      chk("R3 empty read", 32'(rbuf), 0);
   endtask

   task automatic t_zext;
      cfg(1, 6'b10_0000);
      send(1, 8'hFF, 0, 1);
      pop_chk("R7 5-bit", mk(0, 0, 1, 1, 8'h1F));
      cfg(1, 6'b10_0010);
      send(1, 8'hFF, 0, 0);
      pop_chk("R7 7-bit", mk(0, 0, 0, 1, 8'h7F));
   endtask

   task automatic t_prio;
      cfg(3, 6'b10_0011);
      rx_stb = 4'b1111; rx_char = 32'h33_22_11_00;
      @(negedge clk);
      rx_stb = '0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 4; i++)
         pop_chk("R4 order", mk(0, 0, 0, i, 8'(i * 8'h11)));
      chk("R4 drained", 32'(rx_done), 0);
   endtask

   task automatic t_disabled;
      cfg(3, 6'b00_0011);
      send(3, 8'h5A, 0, 0);
      chk("R5 dropped", 32'(rbuf), 0);
   endtask

   task automatic t_break;
      send(0, 8'h00, 1, 0);
      pop_chk("R8 break", mk(0, 1, 0, 0, 8'h00));
      send(2, 8'h3C, 1, 1);
      pop_chk("R8 flags", mk(0, 1, 1, 2, 8'h3C));
   endtask

   task automatic t_irq;
      send(0, 8'h42, 0, 0);
      chk("R10 irq masked", 32'(irq), 0);
      rx_ie = 1'b1; #1;
      chk("R10 irq on", 32'(irq), 1);
      pop_chk("R10 word", mk(0, 0, 0, 0, 8'h42));
      chk("R10 irq off", 32'(irq), 0);
      rx_ie = 1'b0;
   endtask

   task automatic t_overrun;
      for (int i = 0; i < 17; i++) send(0, 8'(i), 0, 0);
      pop_chk("R9 first", mk(0, 0, 0, 0, 8'h00));
      send(0, 8'h40, 0, 0);
      for (int i = 1; i < 16; i++) pop_chk("R9 kept", mk(0, 0, 0, 0, 8'(i)));
      pop_chk("R9 marked", mk(1, 0, 0, 0, 8'h40));
      chk("R9 empty", 32'(rbuf), 0);
      send(0, 8'h41, 0, 0);
      pop_chk("R9 mark once", mk(0, 0, 0, 0, 8'h41));
   endtask

   task automatic t_scan;
      scan_en = 1'b0;
      send(0, 8'h77, 0, 0);
      @(negedge clk);
      chk("R11 no store", 32'(rx_done), 0);
      scan_en = 1'b1;
      @(negedge clk);
      chk("R11 not held", 32'(rbuf), 0);
   endtask

   task automatic t_clear;
      send(0, 8'h01, 0, 0);
      send(1, 8'h02, 0, 0);
      send(2, 8'h03, 0, 0);
      chk("R12 filled", 32'(rx_done), 1);
      clr_cmd = 1'b1; @(negedge clk); clr_cmd = 1'b0;
      chk("R12 cleared", 32'(rx_done), 0);
      chk("R12 rbuf", 32'(rbuf), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      scan_en = 1'b1;
      t_cfg;
      t_single;
      t_zext;
      t_prio;
      t_disabled;
      t_break;
      t_irq;
      t_overrun;
      t_scan;
      t_clear;
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule